// File: doc/BRIEF.md
# FIFO Level Crossing Event Generator

This block sits beside a transmit FIFO and a receive FIFO of the same depth and turns their fill counts into one-cycle event pulses. Each direction has a 3-bit level selector that picks a fractional trigger point. The trigger points are a quarter, a half, three quarters, the extreme, and a single-entry point meant for DMA-style servicing. An event fires only when the fill count moves across the chosen point toward the condition. It does not fire while the count stays on the triggered side.

The block also gives registered full and empty status for both FIFOs. A flush input marks the cycle in which the FIFO pointers are cleared. In that cycle the sudden drop in fill is not reported as a crossing. The FIFO storage and any interrupt masking sit outside this block.

Top module: `fifo_lvl_evt`

## Requirements
- R1: RX selector encodings, with D the depth. Code 1 means count >= D/4. Code 2 means count >= D/2. Code 3 means count >= 3D/4. Code 5 means count == D. Code 7 means count >= 1.
- R2: TX selector encodings, with D the depth. Code 1 means count <= 3D/4. Code 2 means count <= D/2. Code 3 means count <= D/4. Code 5 means count == 0. Code 7 means count <= D-1.
- R3: An event pulses high for exactly one cycle, one clock edge after a count is sampled. It fires only when the condition is true for the newly sampled count and false for the count sampled one edge earlier. It does not fire again while the count stays on the triggered side.
- R4: Selector codes 0, 4 and 6 never produce an event on either direction.
- R5: A change of selector while the count is unchanged produces no event. Both the old and the new count are always judged against the selector present at that edge.
- R6: When flush is high at an edge, neither event fires at that edge. The count sampled then becomes the reference for the next edge, so a drop to zero during a flush is never reported afterwards.
- R7: Status flags are registered one edge after the count: rx_not_full = (rx_count != D), rx_empty = (rx_count == 0), tx_not_full = (tx_count != D), tx_empty = (tx_count == 0).
- R8: During and directly after reset both events are 0 and all four status flags are 1. The reference counts start at zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| flush | input | 1 | FIFO pointers are being cleared this cycle |
| tx_count | input | $clog2(DEPTH+1) | Transmit FIFO fill count |
| rx_count | input | $clog2(DEPTH+1) | Receive FIFO fill count |
| tx_sel | input | 3 | Transmit trigger level selector |
| rx_sel | input | 3 | Receive trigger level selector |
| tx_evt | output | 1 | Transmit level crossing pulse |
| rx_evt | output | 1 | Receive level crossing pulse |
| tx_not_full | output | 1 | Transmit FIFO not full |
| tx_empty | output | 1 | Transmit FIFO empty |
| rx_not_full | output | 1 | Receive FIFO not full |
| rx_empty | output | 1 | Receive FIFO empty |

## Verification
Two pairs of inputs can change at the same edge.

- **Flush with a crossing.** A flush can land at the same edge as a count movement that would otherwise cross a threshold. The stimulus provokes this with a directed flush while the transmit count drops from full to empty under the empty selector, and with random flushes during random walks. The result is judged by expecting both events to stay low at that edge and at the following one.
- **Selector change with a count step.** A selector change can coincide with a count step. The random walk changes selectors mid-stream. The bench model judges each edge by applying the new selector to both the old and the new count, and a directed case holds the count still while the selector moves.

// File: rtl/fle_pkg.sv
package fle_pkg;

   // Trigger level selector encodings (shared by both directions; meaning
   // of the fraction is mirrored for the transmit side).
   typedef enum logic [2:0] {
      LVL_RSV0 = 3'd0,
      LVL_QTR  = 3'd1,
      LVL_HALF = 3'd2,
      LVL_3QTR = 3'd3,
      LVL_RSV4 = 3'd4,
      LVL_EDGE = 3'd5,
      LVL_RSV6 = 3'd6,
      LVL_ONE  = 3'd7
   } lvl_sel_e;

   typedef enum logic {
      DIR_TX = 1'b0,
      DIR_RX = 1'b1
   } fifo_dir_e;

   typedef struct packed {
      logic not_full;
      logic empty;
   } fill_flags_t;

endpackage

// File: rtl/fle_level_match.sv
// Combinational decode of a fill count against the selected trigger level.
module fle_level_match
   import fle_pkg::*;
#(
   parameter int        DEPTH = 16,
   parameter int        CNT_W = 5,
   parameter fifo_dir_e DIR   = DIR_RX
) (
   input  logic [CNT_W-1:0] cnt,
   input  logic [2:0]       sel,
   output logic             hit
);

   localparam logic [CNT_W-1:0] LIM_QTR  = CNT_W'(DEPTH / 4);
   localparam logic [CNT_W-1:0] LIM_HALF = CNT_W'(DEPTH / 2);
   localparam logic [CNT_W-1:0] LIM_3QTR = CNT_W'((3 * DEPTH) / 4);
   localparam logic [CNT_W-1:0] LIM_FULL = CNT_W'(DEPTH);
   localparam logic [CNT_W-1:0] LIM_ONE  = CNT_W'(1);
   localparam logic [CNT_W-1:0] LIM_SPARE = CNT_W'(DEPTH - 1);

   generate
      if (DIR == DIR_RX) begin : g_rx
         // Receive side: fires as the FIFO fills up to the level.
         always_comb begin
            case (lvl_sel_e'(sel))
               LVL_QTR:  hit = (cnt >= LIM_QTR);
               LVL_HALF: hit = (cnt >= LIM_HALF);
               LVL_3QTR: hit = (cnt >= LIM_3QTR);
               LVL_EDGE: hit = (cnt == LIM_FULL);
               LVL_ONE:  hit = (cnt >= LIM_ONE);
               default:  hit = 1'b0;
            endcase
         end
      end else begin : g_tx
         // Transmit side: fires as the FIFO drains down to the level.
         always_comb begin
            case (lvl_sel_e'(sel))
               LVL_QTR:  hit = (cnt <= LIM_3QTR);
               LVL_HALF: hit = (cnt <= LIM_HALF);
               LVL_3QTR: hit = (cnt <= LIM_QTR);
               LVL_EDGE: hit = (cnt == '0);
               LVL_ONE:  hit = (cnt <= LIM_SPARE);
               default:  hit = 1'b0;
            endcase
         end
      end
   endgenerate

endmodule

// File: rtl/fle_cross.sv
// Crossing detector: remembers the previous count and pulses when the
// condition turns true under the selector present at this edge.
module fle_cross
   import fle_pkg::*;
#(
   parameter int        DEPTH = 16,
   parameter int        CNT_W = 5,
   parameter fifo_dir_e DIR   = DIR_RX
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             flush,
   input  logic [CNT_W-1:0] cnt,
   input  logic [2:0]       sel,
   output logic             evt
);

   logic [CNT_W-1:0] ref_q;
   logic             hit_now;
   logic             hit_ref;
   logic             evt_q;

   fle_level_match #(.DEPTH(DEPTH), .CNT_W(CNT_W), .DIR(DIR)) u_now (
      .cnt (cnt),
      .sel (sel),
      .hit (hit_now)
   );

   fle_level_match #(.DEPTH(DEPTH), .CNT_W(CNT_W), .DIR(DIR)) u_ref (
      .cnt (ref_q),
      .sel (sel),
      .hit (hit_ref)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ref_q <= '0;
         evt_q <= 1'b0;
      end else begin
         ref_q <= cnt;
         evt_q <= hit_now & ~hit_ref & ~flush;
      end
   end

   assign evt = evt_q;

endmodule

// File: rtl/fle_fill_flags.sv
// Registered full/empty status for one FIFO.
module fle_fill_flags
   import fle_pkg::*;
#(
   parameter int DEPTH = 16,
   parameter int CNT_W = 5
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [CNT_W-1:0] cnt,
   output fill_flags_t      flags
);

   localparam logic [CNT_W-1:0] LIM_FULL = CNT_W'(DEPTH);

   fill_flags_t flags_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         flags_q <= '{not_full: 1'b1, empty: 1'b1};
      end else begin
         flags_q.not_full <= (cnt != LIM_FULL);
         flags_q.empty    <= (cnt == '0);
      end
   end

   assign flags = flags_q;

endmodule

// File: rtl/fifo_lvl_evt.sv
module fifo_lvl_evt
   import fle_pkg::*;
#(
   parameter int DEPTH = 16,
   localparam int CNT_W = $clog2(DEPTH + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             flush,
   input  logic [CNT_W-1:0] tx_count,
   input  logic [CNT_W-1:0] rx_count,
   input  logic [2:0]       tx_sel,
   input  logic [2:0]       rx_sel,
   output logic             tx_evt,
   output logic             rx_evt,
   output logic             tx_not_full,
   output logic             tx_empty,
   output logic             rx_not_full,
   output logic             rx_empty
);

   localparam int NDIR = 2;

   generate
      if (DEPTH < 4 || (DEPTH % 4) != 0) begin : g_bad_depth
         $error("fifo_lvl_evt: DEPTH must be a multiple of 4 and at least 4");
      end
   endgenerate

   logic [CNT_W-1:0] cnt_a [NDIR];
   logic [2:0]       sel_a [NDIR];
   logic             evt_a [NDIR];
   fill_flags_t      flg_a [NDIR];

   // Index 0 is transmit, index 1 is receive (matches fifo_dir_e).
   assign cnt_a[0] = tx_count;
   assign cnt_a[1] = rx_count;
   assign sel_a[0] = tx_sel;
   assign sel_a[1] = rx_sel;

   generate
      for (genvar d = 0; d < NDIR; d++) begin : g_dir
         fle_cross #(
            .DEPTH (DEPTH),
            .CNT_W (CNT_W),
            .DIR   (fifo_dir_e'(d))
         ) u_cross (
            .clk   (clk),
            .rst_n (rst_n),
            .flush (flush),
            .cnt   (cnt_a[d]),
            .sel   (sel_a[d]),
            .evt   (evt_a[d])
         );

         fle_fill_flags #(
            .DEPTH (DEPTH),
            .CNT_W (CNT_W)
         ) u_flags (
            .clk   (clk),
            .rst_n (rst_n),
            .cnt   (cnt_a[d]),
            .flags (flg_a[d])
         );
      end
   endgenerate

   assign tx_evt      = evt_a[0];
   assign rx_evt      = evt_a[1];
   assign tx_not_full = flg_a[0].not_full;
   assign tx_empty    = flg_a[0].empty;
   assign rx_not_full = flg_a[1].not_full;
   assign rx_empty    = flg_a[1].empty;

endmodule

// File: rtl/fle_evt_checker.sv
module fle_evt_checker #(
   parameter int DEPTH = 16,
   localparam int CNT_W = $clog2(DEPTH + 1)
) (
   input logic             clk,
   input logic             rst_n,
   input logic             flush,
   input logic [CNT_W-1:0] tx_count,
   input logic [CNT_W-1:0] rx_count,
   input logic [2:0]       tx_sel,
   input logic [2:0]       rx_sel,
   input logic             tx_evt,
   input logic             rx_evt,
   input logic             tx_not_full,
   input logic             tx_empty,
   input logic             rx_not_full,
   input logic             rx_empty
);

   localparam logic [CNT_W-1:0] FULL_C = CNT_W'(DEPTH);

   logic rx_rsv;
   logic tx_rsv;
   assign rx_rsv = (rx_sel == 3'd0) || (rx_sel == 3'd4) || (rx_sel == 3'd6);
   assign tx_rsv = (tx_sel == 3'd0) || (tx_sel == 3'd4) || (tx_sel == 3'd6);

   AST_RX_EVT_NEEDS_DATA: assert property (@(posedge clk) disable iff (!rst_n)
      rx_evt |-> ($past(rx_count) != '0)); // R1
   AST_TX_EVT_NEEDS_ROOM: assert property (@(posedge clk) disable iff (!rst_n)
      tx_evt |-> ($past(tx_count) != FULL_C)); // R2
   AST_RX_RESERVED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      rx_evt |-> !$past(rx_rsv)); // R4
   AST_TX_RESERVED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      tx_evt |-> !$past(tx_rsv)); // R4
   AST_RX_HELD_NO_EVT: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_evt && $stable(rx_sel) && ($past(rx_count) == rx_count)) |=> !rx_evt); // R3
   AST_FLUSH_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
      $past(flush) |-> (!tx_evt && !rx_evt)); // R6
   AST_RX_FLAGS_SANE: assert property (@(posedge clk) disable iff (!rst_n)
      !(rx_empty && !rx_not_full)); // R7
   AST_TX_FLAGS_SANE: assert property (@(posedge clk) disable iff (!rst_n)
      !(tx_empty && !tx_not_full)); // R7
   AST_RX_NOT_EMPTY_SRC: assert property (@(posedge clk) disable iff (!rst_n)
      !rx_empty |-> ($past(rx_count) != '0)); // R7
   AST_COUNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_count <= FULL_C) && (tx_count <= FULL_C)); // R7

endmodule

bind fifo_lvl_evt fle_evt_checker #(.DEPTH(DEPTH)) u_fle_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .flush       (flush),
   .tx_count    (tx_count),
   .rx_count    (rx_count),
   .tx_sel      (tx_sel),
   .rx_sel      (rx_sel),
   .tx_evt      (tx_evt),
   .rx_evt      (rx_evt),
   .tx_not_full (tx_not_full),
   .tx_empty    (tx_empty),
   .rx_not_full (rx_not_full),
   .rx_empty    (rx_empty)
);

// File: tb/tb_fifo_lvl_evt.sv
module tb_fifo_lvl_evt;

   localparam int D  = 16;
   localparam int CW = $clog2(D + 1);

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          flush = 1'b0;
   logic [CW-1:0] tx_count = '0;
   logic [CW-1:0] rx_count = '0;
   logic [2:0]    tx_sel = 3'd2;
   logic [2:0]    rx_sel = 3'd2;
   logic          tx_evt, rx_evt, tx_not_full, tx_empty, rx_not_full, rx_empty;

   int n_checks = 0;
   int n_fail   = 0;
   int prev_tc  = 0;
   int prev_rc  = 0;
   bit done     = 1'b0;

   always #4 clk = ~clk;

   fifo_lvl_evt #(.DEPTH(D)) dut (
      .clk(clk), .rst_n(rst_n), .flush(flush),
      .tx_count(tx_count), .rx_count(rx_count),
      .tx_sel(tx_sel), .rx_sel(rx_sel),
      .tx_evt(tx_evt), .rx_evt(rx_evt),
      .tx_not_full(tx_not_full), .tx_empty(tx_empty),
      .rx_not_full(rx_not_full), .rx_empty(rx_empty)
   );

   function automatic bit cond_rx(int c, int s);
      case (s)
         1: return c >= D / 4;
         2: return c >= D / 2;
         3: return c >= (3 * D) / 4;
         5: return c == D;
         7: return c >= 1;
         default: return 1'b0;
      endcase
   endfunction

   function automatic bit cond_tx(int c, int s);
      case (s)
         1: return c <= (3 * D) / 4;
         2: return c <= D / 2;
         3: return c <= D / 4;
         5: return c == 0;
         7: return c <= D - 1;
         default: return 1'b0;
      endcase
   endfunction

   task automatic check(string tag, string what, logic act, logic exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s actual=%0b expected=%0b (t=%0t)", tag, what, act, exp, $time);
      end
   endtask

   task automatic report();
      if (!done) begin
         done = 1'b1;
         $display("  TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
      end
   endtask

   // Drive at a falling edge, let one rising edge pass, check at the next falling edge.
   task automatic apply(int tc, int rc, int ts, int rs, bit fl, string tag);
      bit ex_tx, ex_rx;
      tx_count = CW'(tc);
      rx_count = CW'(rc);
      tx_sel   = 3'(ts);
      rx_sel   = 3'(rs);
      flush    = fl;
      ex_tx = !fl && cond_tx(tc, ts) && !cond_tx(prev_tc, ts);
      ex_rx = !fl && cond_rx(rc, rs) && !cond_rx(prev_rc, rs);
      @(posedge clk);
      @(negedge clk);
      check(tag, "tx_evt", tx_evt, ex_tx);
      check(tag, "rx_evt", rx_evt, ex_rx);
      check("R7", "tx_not_full", tx_not_full, tc != D);
      check("R7", "tx_empty", tx_empty, tc == 0);
      check("R7", "rx_not_full", rx_not_full, rc != D);
      check("R7", "rx_empty", rx_empty, rc == 0);
      prev_tc = tc;
      prev_rc = rc;
   endtask

   initial begin
      #1_000_000;
      n_checks++;
      n_fail++;
      $display("FAIL watchdog expired actual=running expected=finished");
      report();
      $finish;
   end

   initial begin
      int tc, rc, ts, rs;
      void'($urandom(32'd20240611));

      // R8: reset state
      repeat (3) @(posedge clk);
      @(negedge clk);
      check("R8", "tx_evt", tx_evt, 1'b0);
      check("R8", "rx_evt", rx_evt, 1'b0);
      check("R8", "tx_not_full", tx_not_full, 1'b1);
      check("R8", "tx_empty", tx_empty, 1'b1);
      check("R8", "rx_not_full", rx_not_full, 1'b1);
      check("R8", "rx_empty", rx_empty, 1'b1);
      rst_n = 1'b1;
      apply(0, 0, 2, 2, 1'b0, "R8");

      // R1: receive fill sweeps under several selectors
      for (int c = 1; c <= D; c++) apply(0, c, 2, 2, 1'b0, "R1");
      apply(0, 0, 2, 7, 1'b0, "R1");
      apply(0, 1, 2, 7, 1'b0, "R1");
      apply(0, D - 1, 2, 5, 1'b0, "R1");
      apply(0, D, 2, 5, 1'b0, "R1");
      apply(0, 0, 2, 3, 1'b0, "R1");
      apply(0, (3 * D) / 4, 2, 3, 1'b0, "R1");

      // R2: transmit drain sweeps
      apply(D, 0, 2, 2, 1'b0, "R2");
      for (int c = D - 1; c >= 0; c--) apply(c, 0, 2, 2, 1'b0, "R2");
      apply(1, 0, 5, 2, 1'b0, "R2");
      apply(0, 0, 5, 2, 1'b0, "R2");
      apply(D, 0, 7, 2, 1'b0, "R2");
      apply(D - 1, 0, 7, 2, 1'b0, "R2");
      apply(D, 0, 1, 2, 1'b0, "R2");
      apply((3 * D) / 4, 0, 1, 2, 1'b0, "R2");

      // R3: one pulse on a jump, silence while held
      apply(D, 0, 3, 1, 1'b0, "R3");
      apply(0, D, 3, 1, 1'b0, "R3");
      for (int k = 0; k < 4; k++) apply(0, D, 3, 1, 1'b0, "R3");

      // R4: reserved codes stay silent through full swings
      for (int s = 0; s < 8; s += 2) begin
         if (s == 2) continue;
         apply(D, 0, s, s, 1'b0, "R4");
         apply(0, D, s, s, 1'b0, "R4");
         apply(D, 0, s, s, 1'b0, "R4");
      end

      // R5: selector moves across a held count
      apply(D / 2 + 2, 10, 3, 3, 1'b0, "R5");
      apply(D / 2 + 2, 10, 1, 1, 1'b0, "R5");
      apply(D / 2 + 2, 10, 2, 2, 1'b0, "R5");

      // R6: flush at the edge where transmit would cross to empty
      apply(D, D, 5, 2, 1'b0, "R6");
      apply(0, 0, 5, 2, 1'b1, "R6");
      apply(0, 0, 5, 2, 1'b0, "R6");
      apply(0, 0, 5, 2, 1'b0, "R6");

      // Random walk with selector changes and occasional flush
      tc = prev_tc; rc = prev_rc; ts = 2; rs = 2;
      for (int i = 0; i < 3000; i++) begin
         if ($urandom_range(0, 9) == 0) tc = int'($urandom_range(0, D));
         else tc = tc + int'($urandom_range(0, 4)) - 2;
         if ($urandom_range(0, 9) == 0) rc = int'($urandom_range(0, D));
         else rc = rc + int'($urandom_range(0, 4)) - 2;
         if (tc < 0) tc = 0;
         if (tc > D) tc = D;
         if (rc < 0) rc = 0;
         if (rc > D) rc = D;
         if ($urandom_range(0, 15) == 0) ts = int'($urandom_range(0, 7));
         if ($urandom_range(0, 15) == 0) rs = int'($urandom_range(0, 7));
         apply(tc, rc, ts, rs, $urandom_range(0, 49) == 0, "R3");
      end

      report();
      $finish;
   end

endmodule